// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Data-Logic Inversion

This block serializes bytes onto a single transmit line in asynchronous start/stop framing. A host writes a byte through a one-cycle write strobe into a single-entry holding buffer. When the serializer is free, the byte moves into a shift register. Each pulse on the external baud clock-enable then advances the line by exactly one bit. The block has no baud generator of its own.

The frame options can be set per frame: 7 or 8 data bits, parity off, even or odd, and one or two stop bits. They are sampled when a byte moves from the buffer into the shifter.

A data-logic select input complements the byte as it is written into the buffer. Data bits and parity therefore leave the block inverted, and parity is computed on the inverted data. Start and stop bits keep their normal levels. Two status outputs report when the buffer is empty and when the whole transmission has finished.

Top module: `serial_tx_inv`

## Requirements
- R1: A synchronous active-high `rst` sets `txd` to 1, `buf_empty` to 1 and `tx_done` to 0.
- R2: When `logic_inv`=1 during a write, the stored byte is the bitwise complement of `wr_data`. When `logic_inv`=0, the byte is stored unchanged. Only the stored value is sent.
- R3: The frame order is: a start bit at 0, then the data bits least-significant first, then the optional parity bit, then the stop bit(s) at 1.
- R3 (timing): `txd` changes only on a clock edge where `baud_tick`=1, and each such tick advances exactly one bit.
- R4: `short_len`=1 sends 7 data bits; bit 7 of the stored byte is not sent. `short_len`=0 sends 8 data bits.
- R5: When `par_en`=1, a parity bit follows the last data bit, and it is computed over the data bits as stored.
- R5 (parity sense): With `par_odd`=0 the XOR of the sent data bits and the parity bit is 0. With `par_odd`=1 that XOR is 1.
- R6: `two_stop`=1 sends two stop bits; `two_stop`=0 sends one.
- R7: The line stays at 1 between frames. A tick that arrives with an empty buffer and an idle serializer leaves `txd` at 1.
- R8: A write made while a frame is being sent is held in the buffer, and `buf_empty` falls on the edge after the write.
- R8 (hand-off): The held byte moves to the shifter on the tick that ends the last stop bit. On that same edge `buf_empty` rises and `txd` drops to start the next frame.
- R9: `tx_done` rises on the tick that ends the last stop bit when no byte is waiting. It stays high until the next write, which clears it on the following edge.
- R10: A write on the same edge as a buffer-to-shifter move sends the previously held byte and keeps the new byte, so `buf_empty` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle enable; each pulse advances one bit |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| logic_inv | input | 1 | 1 = complement the byte on write |
| short_len | input | 1 | 1 = 7 data bits, 0 = 8 |
| par_en | input | 1 | 1 = append parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| two_stop | input | 1 | 1 = two stop bits |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding buffer holds no byte |
| tx_done | output | 1 | All frames finished and buffer empty |

## Verification
Two events can fall on the same edge: a host write, and the stop-bit-ending tick that moves the held byte into the shifter. The bench arranges this by first filling the buffer during a frame. It then raises `wr_en` and `baud_tick` in the same cycle at the last stop bit.

The check has three parts:
- `buf_empty` must stay low.
- The next frame on the line must carry the older byte.
- The newer byte must follow in the frame after that.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef struct packed {
    logic short_len;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } tx_cfg_t;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              invert,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_out
);
  // Inversion is applied once, on the way in; a write beats a take.
  always_ff @(posedge clk) begin
    if (rst) begin
      full     <= 1'b0;
      data_out <= '0;
    end else if (wr_en) begin
      data_out <= invert ? ~wr_data : wr_data;
      full     <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
  import serial_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 3,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  tx_cfg_t            cfg,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  logic [CNT_W-1:0]  len;
  logic [DATA_W-1:0] mask;
  logic              par;

  always_comb begin
    len  = cfg.short_len ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
    mask = cfg.short_len ? {1'b0, {(DATA_W-1){1'b1}}} : '1;
    par  = (^(data & mask)) ^ cfg.par_odd;
    frame = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (CNT_W'(i) < len) frame[i] = data[i];
    end
    if (cfg.par_en) frame[len] = par;
    nbits = len + CNT_W'(cfg.par_en) + CNT_W'(1) + CNT_W'(cfg.two_stop);
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int FRAME_W = 11,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               have_data,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  output logic               take,
  output logic               finish,
  output logic               txd
);
  logic               busy;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   remain;
  logic               last;

  assign last   = busy && (remain == '0);
  assign take   = tick && have_data && (!busy || last);
  assign finish = tick && last && !have_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sreg   <= '1;
      remain <= '0;
      txd    <= 1'b1;
    end else if (take) begin
      busy   <= 1'b1;
      sreg   <= frame_in;
      remain <= nbits_in;
      txd    <= 1'b0;
    end else if (finish) begin
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (tick && busy) begin
      txd    <= sreg[0];
      sreg   <= {1'b1, sreg[FRAME_W-1:1]};
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/serial_tx_inv.sv
module serial_tx_inv
  import serial_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              logic_inv,
  input  logic              short_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               full, take, finish;
  logic [DATA_W-1:0]  held;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  tx_cfg_t            cfg;

  assign cfg = '{short_len: short_len, par_en: par_en,
                 par_odd: par_odd, two_stop: two_stop};

  tx_hold_buf #(.DATA_W(DATA_W)) buf_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .invert(logic_inv), .take(take), .full(full), .data_out(held)
  );

  tx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) bld_i (
    .data(held), .cfg(cfg), .frame(frame), .nbits(nbits)
  );

  tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shf_i (
    .clk(clk), .rst(rst), .tick(baud_tick), .have_data(full),
    .frame_in(frame), .nbits_in(nbits), .take(take), .finish(finish),
    .txd(txd)
  );

  assign buf_empty = ~full;

  always_ff @(posedge clk) begin
    if (rst)         tx_done <= 1'b0;
    else if (wr_en)  tx_done <= 1'b0;
    else if (finish) tx_done <= 1'b1;
  end
endmodule

// File: rtl/serial_tx_inv_chk.sv
module serial_tx_inv_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic wr_en,
  input logic txd,
  input logic buf_empty,
  input logic tx_done
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (txd && buf_empty && !tx_done));

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(txd));

  // R8
  write_fills_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !buf_empty);

  // R8
  handoff_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_empty) |-> !txd);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> (txd && buf_empty));
endmodule

bind serial_tx_inv serial_tx_inv_chk chk_i (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
  .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
);

// File: tb/serial_tx_inv_tb_top.sv
module serial_tx_inv_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic logic_inv = 0, short_len = 0, par_en = 0, par_odd = 0, two_stop = 0;
  logic txd, buf_empty, tx_done;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  serial_tx_inv dut_i (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .logic_inv(logic_inv), .short_len(short_len),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done)
  );

  // {data, inv, short, par_en, par_odd, two_stop}
  localparam logic [12:0] VEC [6] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h81, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h6E, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [7:0] d, input logic inv, sh,
                                    pe, po, ts, output logic [11:0] b,
                                    output int n);
    logic [7:0] s;
    int w;
    logic p;
    s = inv ? ~d : d;
    w = sh ? 7 : 8;
    b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < w; i++) b[1+i] = s[i];
    n = 1 + w;
    if (pe) begin
      p = po;
      for (int i = 0; i < w; i++) p ^= s[i];
      b[n] = p;
      n++;
    end
    b[n] = 1'b1;
    n++;
    if (ts) begin
      b[n] = 1'b1;
      n++;
    end
  endfunction

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
  endtask

  task automatic write(input logic [7:0] d, input logic inv);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; logic_inv = inv; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  // Ticks through bits from..n-1 and compares each one.
  task automatic walk(input logic [11:0] b, input int from, input int n,
                      input string tag);
    for (int k = from; k < n; k++) begin
      tick();
      chk(txd, b[k], tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] b, b2;
    int n, n2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd, 1'b1, "R1 txd");
    chk(buf_empty, 1'b1, "R1 buf_empty");
    chk(tx_done, 1'b0, "R1 tx_done");
    tick();
    chk(txd, 1'b1, "R7 idle tick");

    // Table-driven frames: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      {short_len, par_en, par_odd, two_stop} = VEC[v][3:0];
      exp_frame(VEC[v][12:5], VEC[v][4], VEC[v][3], VEC[v][2], VEC[v][1],
                VEC[v][0], b, n);
      write(VEC[v][12:5], VEC[v][4]);
      chk(tx_done, 1'b0, "R9 cleared by write");
      chk(buf_empty, 1'b0, "R8 write fills");
      walk(b, 0, n, "R2/R3/R4/R5/R6 frame bit");
      chk(txd, 1'b1, "R6 last stop");
      chk(tx_done, 1'b0, "R9 not before stop ends");
      tick();
      chk(tx_done, 1'b1, "R9 done");
      chk(buf_empty, 1'b1, "R9 empty at done");
      chk(txd, 1'b1, "R7 idle after frame");
      repeat (2) @(negedge clk);
      chk(txd, 1'b1, "R7 idle hold");
    end

    // Back-to-back hand-off: R8
    {short_len, par_en, par_odd, two_stop} = 4'b0000;
    exp_frame(8'h5A, 0, 0, 0, 0, 0, b, n);
    write(8'h5A, 1'b0);
    tick();
    chk(txd, 1'b0, "R3 start");
    chk(buf_empty, 1'b1, "R8 moved to shifter");
    write(8'h3C, 1'b1);
    chk(buf_empty, 1'b0, "R8 held during frame");
    walk(b, 1, n, "R8 first frame");
    chk(buf_empty, 1'b0, "R8 still held");
    tick();
    chk(txd, 1'b0, "R8 next start at stop end");
    chk(buf_empty, 1'b1, "R8 empty at hand-off");
    chk(tx_done, 1'b0, "R9 not done with data waiting");

    // Refill, then write on the same edge as the hand-off: R10
    exp_frame(8'h3C, 1, 0, 0, 0, 0, b, n);
    write(8'h96, 1'b0);
    walk(b, 1, n, "R2 inverted second frame");
    @(negedge clk) begin
      baud_tick = 1'b1; wr_en = 1'b1; wr_data = 8'h0F; logic_inv = 1'b0;
    end
    @(negedge clk) begin baud_tick = 1'b0; wr_en = 1'b0; end
    chk(buf_empty, 1'b0, "R10 buffer keeps new byte");
    chk(txd, 1'b0, "R10 start of held byte");
    exp_frame(8'h96, 0, 0, 0, 0, 0, b, n);
    walk(b, 1, n, "R10 older byte first");
    tick();
    chk(txd, 1'b0, "R10 newer byte start");
    exp_frame(8'h0F, 0, 0, 0, 0, 0, b2, n2);
    walk(b2, 1, n2, "R10 newer byte");
    tick();
    chk(tx_done, 1'b1, "R9 done after chain");

    // Reset mid-frame: R1
    write(8'h00, 1'b0);
    tick();
    tick();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk(txd, 1'b1, "R1 txd after reset");
    chk(buf_empty, 1'b1, "R1 buf_empty after reset");
    chk(tx_done, 1'b0, "R1 tx_done after reset");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule